// File: doc/BRIEF.md
# Audio Transmit FIFO with Sample Packing

This block sits on the transmit side of an audio serial interface, between the host and the serial shifter. The host writes 32-bit words. The block can store each word as one entry, or split it into two half-word entries, each zero-padded in its low half. The shifter pops entries, and a 3-bit read format turns them into a left/right sample pair. The format selects 16 or 32 bits and one or two channels.

Two level flags help the host pace its traffic:
- **canAccept** compares the transmit occupancy with a programmable threshold. It says the host may keep writing.
- **needDrain** compares a receive-side occupancy, supplied on a port, with its own threshold. It says the receive buffer must be emptied.

A single enable bit gates both packing choices. When the bit is clear, the block falls back to plain words and 32-bit stereo.

Two sticky bits record errors. Overflow records a write that did not fit. Underflow records a pop that had too few entries. Both clear through a one-cycle strobe.

Top module: `atx_top`

## Requirements
- R1: With forceEn=1 and wrSplit=0, each accepted write stores wrData as one entry. Entries leave in the order they were written.
- R2: With forceEn=1 and wrSplit=1, an accepted write of D stores two entries: first {D[31:16],16'h0}, then {D[15:0],16'h0}. Level rises by 2.
- R3: With forceEn=1, rdMode selects the read format:
  - 0: 16-bit dual.
  - 1: 16-bit single.
  - 2: 32-bit dual.
  - 3: 32-bit single.
  - 4 to 7: same as 2.
- R4: A dual pop removes two entries: leftOut gets the older entry, rightOut the next one. A single pop removes one entry and drives it on both outputs. In 16-bit formats, each output carries the upper half of its entry with the lower 16 bits forced to zero.
- R5: With forceEn=0, wrSplit has no effect (one entry per write) and every pop uses format 2, whatever rdMode holds.
- R6: canAccept is 1 exactly when level < txThresh.
- R7: needDrain is 1 exactly when rxLevel > rxThresh.
- R8: level ranges over 0 to 64.
  - A write that lacks room is dropped whole: one free entry is needed, or two when splitting.
  - A dropped write sets overflow, and overflow stays set.
- R9: A pop with fewer entries than its format needs removes nothing. It drives zero on both outputs and sets underflow, which stays set.
- R10: clrSticky clears overflow and underflow in the next cycle, unless a new error occurs in that same cycle.
- R11: A pop request (good or underflowing) is seen at a clock edge. After that edge, outValid is 1 for one cycle and the new samples are on leftOut/rightOut. Without a pop, outValid is 0 and both outputs hold their values.
- R12: After reset:
  - level = 0 and outValid = 0.
  - leftOut = rightOut = 0.
  - overflow = underflow = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| forceEn | input | 1 | Enables wrSplit and rdMode |
| wrValid | input | 1 | Host write strobe |
| wrSplit | input | 1 | Split each word into two half-word entries |
| wrData | input | 32 | Host word |
| popReq | input | 1 | Shifter requests one sample pair |
| rdMode | input | 3 | Read format |
| leftOut | output | 32 | Left sample |
| rightOut | output | 32 | Right sample |
| outValid | output | 1 | New sample pair present |
| level | output | 7 | Entries buffered |
| txThresh | input | 6 | Transmit threshold |
| canAccept | output | 1 | level < txThresh |
| rxLevel | input | 7 | Receive-side occupancy |
| rxThresh | input | 6 | Receive threshold |
| needDrain | output | 1 | rxLevel > rxThresh |
| clrSticky | input | 1 | Clears overflow and underflow |
| overflow | output | 1 | Sticky dropped-write flag |
| underflow | output | 1 | Sticky short-pop flag |

## Verification
The hardest state to reach is a FIFO holding 63 entries. There, a plain word still fits but a split word does not, so the two-entry room check can be seen apart from the plain full check. The bench fills the FIFO with 63 numbered words and offers a split word, which must be dropped. It then clears the sticky flag, adds one plain word to reach 64, and offers one more. Finally it pops the oldest entry to show that no dropped data displaced stored data.

// File: rtl/atx_pkg.sv
package atx_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic push;   // store write data
    logic split;  // store as two half-word entries
    logic pop;    // consume entries and present them
    logic dual;   // two entries per pop
    logic half;   // 16-bit samples
    logic zero;   // short pop: present zeros
  } atx_strobe_t;

  localparam logic [2:0] MODE_H_DUAL = 3'd0;
  localparam logic [2:0] MODE_H_SINGLE = 3'd1;
  localparam logic [2:0] MODE_W_DUAL = 3'd2;
  localparam logic [2:0] MODE_W_SINGLE = 3'd3;
endpackage

// File: rtl/atx_ctrl.sv
module atx_ctrl
  import atx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TH_W = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             forceEn,
  input  logic             wrValid,
  input  logic             wrSplit,
  input  logic             popReq,
  input  logic [2:0]       rdMode,
  input  logic             clrSticky,
  input  logic [TH_W-1:0]  txThresh,
  input  logic [CNT_W-1:0] rxLevel,
  input  logic [TH_W-1:0]  rxThresh,
  output atx_strobe_t      strobe,
  output logic [CNT_W-1:0] level,
  output logic             canAccept,
  output logic             needDrain,
  output logic             overflow,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [2:0] effMode;
  logic effSplit, isSingle, isHalf, pushOk, popOk;
  logic [CNT_W-1:0] pushAmt, popNeed, freeCnt;

  always_comb begin
    effSplit = forceEn & wrSplit;
    effMode  = forceEn ? rdMode : MODE_W_DUAL;
    isSingle = (effMode == MODE_H_SINGLE) || (effMode == MODE_W_SINGLE);
    isHalf   = (effMode == MODE_H_DUAL) || (effMode == MODE_H_SINGLE);
    pushAmt  = effSplit ? CNT_W'(2) : CNT_W'(1);
    popNeed  = isSingle ? CNT_W'(1) : CNT_W'(2);
    freeCnt  = DEPTH_C - level;
    pushOk   = wrValid && (freeCnt >= pushAmt);
    popOk    = popReq && (level >= popNeed);
    strobe.push  = pushOk;
    strobe.split = effSplit;
    strobe.pop   = popOk;
    strobe.dual  = ~isSingle;
    strobe.half  = isHalf;
    strobe.zero  = popReq & ~popOk;
  end

  assign canAccept = level < CNT_W'(txThresh);
  assign needDrain = rxLevel > CNT_W'(rxThresh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      level     <= level + (pushOk ? pushAmt : '0) - (popOk ? popNeed : '0);
      overflow  <= (overflow & ~clrSticky) | (wrValid & ~pushOk);
      underflow <= (underflow & ~clrSticky) | (popReq & ~popOk);
    end
  end
endmodule

// File: rtl/atx_datapath.sv
module atx_datapath
  import atx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  atx_strobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] leftOut,
  output logic [DATA_W-1:0] rightOut,
  output logic              outValid
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr, wrPtrNext, rdPtrNext;
  logic [DATA_W-1:0] hiEntry, loEntry, fmtA, fmtB;

  assign wrPtrNext = wrPtr + ADDR_W'(1);
  assign rdPtrNext = rdPtr + ADDR_W'(1);
  assign hiEntry = {wrData[DATA_W-1:HALF_W], {HALF_W{1'b0}}};
  assign loEntry = {wrData[HALF_W-1:0], {HALF_W{1'b0}}};

  function automatic logic [DATA_W-1:0] fmtSample(input logic [DATA_W-1:0] e, input logic half);
    return half ? {e[DATA_W-1:HALF_W], {HALF_W{1'b0}}} : e;
  endfunction

  assign fmtA = fmtSample(mem[rdPtr], strobe.half);
  assign fmtB = strobe.dual ? fmtSample(mem[rdPtrNext], strobe.half) : fmtA;

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      mem[wrPtr] <= strobe.split ? hiEntry : wrData;
      if (strobe.split) mem[wrPtrNext] <= loEntry;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      leftOut  <= '0;
      rightOut <= '0;
      outValid <= 1'b0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + (strobe.split ? ADDR_W'(2) : ADDR_W'(1));
      outValid <= strobe.pop | strobe.zero;
      if (strobe.zero) begin
        leftOut  <= '0;
        rightOut <= '0;
      end else if (strobe.pop) begin
        leftOut  <= fmtA;
        rightOut <= fmtB;
        rdPtr    <= rdPtr + (strobe.dual ? ADDR_W'(2) : ADDR_W'(1));
      end
    end
  end
endmodule

// File: rtl/atx_top.sv
module atx_top
  import atx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DATA_W = 32,
  parameter int TH_W = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              forceEn,
  input  logic              wrValid,
  input  logic              wrSplit,
  input  logic [DATA_W-1:0] wrData,
  input  logic              popReq,
  input  logic [2:0]        rdMode,
  output logic [DATA_W-1:0] leftOut,
  output logic [DATA_W-1:0] rightOut,
  output logic              outValid,
  output logic [CNT_W-1:0]  level,
  input  logic [TH_W-1:0]   txThresh,
  output logic              canAccept,
  input  logic [CNT_W-1:0]  rxLevel,
  input  logic [TH_W-1:0]   rxThresh,
  output logic              needDrain,
  input  logic              clrSticky,
  output logic              overflow,
  output logic              underflow
);
  atx_strobe_t strobe;

  atx_ctrl #(.DEPTH(DEPTH), .TH_W(TH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .forceEn(forceEn), .wrValid(wrValid), .wrSplit(wrSplit),
    .popReq(popReq), .rdMode(rdMode), .clrSticky(clrSticky), .txThresh(txThresh),
    .rxLevel(rxLevel), .rxThresh(rxThresh), .strobe(strobe), .level(level),
    .canAccept(canAccept), .needDrain(needDrain), .overflow(overflow), .underflow(underflow)
  );

  atx_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .leftOut(leftOut), .rightOut(rightOut), .outValid(outValid)
  );
endmodule

// File: rtl/atx_checker.sv
module atx_checker #(
  parameter int DEPTH = 64,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic              popReq,
  input logic              clrSticky,
  input logic [CNT_W-1:0]  level,
  input logic [DATA_W-1:0] leftOut,
  input logic              outValid,
  input logic              overflow,
  input logic              underflow
);
  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    level <= CNT_W'(DEPTH));

  assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && level == CNT_W'(DEPTH)) |=> overflow);

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !clrSticky) |=> overflow);

  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && level == '0) |=> (underflow && outValid && leftOut == '0));

  assert_clear_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clrSticky && !wrValid && !popReq) |=> (!overflow && !underflow));

  assert_hold_no_pop_R11: assert property (@(posedge clk) disable iff (!rstN)
    !popReq |=> (!outValid && $stable(leftOut)));
endmodule

bind atx_top atx_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .popReq(popReq), .clrSticky(clrSticky),
  .level(level), .leftOut(leftOut), .outValid(outValid),
  .overflow(overflow), .underflow(underflow)
);

// File: tb/test_atx_top.sv
module test_atx_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic        split;
    logic [31:0] data;
    logic        pop;
    logic [2:0]  mode;
    logic        expValid;
    logic [31:0] expLeft;
    logic [31:0] expRight;
    logic [6:0]  expLevel;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b0, 32'h11112222, 1'b0, 3'd0, 1'b0, 32'h0, 32'h0, 7'd1},               // R1
    '{1'b1, 1'b1, 32'hAAAABBBB, 1'b0, 3'd0, 1'b0, 32'h0, 32'h0, 7'd3},               // R2
    '{1'b0, 1'b0, 32'h0, 1'b1, 3'd3, 1'b1, 32'h11112222, 32'h11112222, 7'd2},        // R3 R4
    '{1'b0, 1'b0, 32'h0, 1'b1, 3'd0, 1'b1, 32'hAAAA0000, 32'hBBBB0000, 7'd0},        // R2 R4
    '{1'b1, 1'b0, 32'h12345678, 1'b0, 3'd0, 1'b0, 32'h0, 32'h0, 7'd1},               // R1
    '{1'b1, 1'b0, 32'h9ABCDEF0, 1'b0, 3'd0, 1'b0, 32'h0, 32'h0, 7'd2},               // R1
    '{1'b0, 1'b0, 32'h0, 1'b1, 3'd1, 1'b1, 32'h12340000, 32'h12340000, 7'd1},        // R3 R4
    '{1'b0, 1'b0, 32'h0, 1'b1, 3'd2, 1'b1, 32'h0, 32'h0, 7'd1},                      // R9
    '{1'b0, 1'b0, 32'h0, 1'b1, 3'd3, 1'b1, 32'h9ABCDEF0, 32'h9ABCDEF0, 7'd0},        // R1 R3
    '{1'b1, 1'b0, 32'h0F0F0F0F, 1'b1, 3'd3, 1'b1, 32'h0, 32'h0, 7'd1}                // R9
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic forceEn = 1'b1, wrValid = 1'b0, wrSplit = 1'b0, popReq = 1'b0, clrSticky = 1'b0;
  logic [31:0] wrData = '0;
  logic [2:0] rdMode = '0;
  logic [5:0] txThresh = 6'd3, rxThresh = 6'd5;
  logic [6:0] rxLevel = '0;
  logic [31:0] leftOut, rightOut;
  logic outValid, canAccept, needDrain, overflow, underflow;
  logic [6:0] level;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atx_top i_atx_top (
    .clk(clk), .rstN(rstN), .forceEn(forceEn), .wrValid(wrValid), .wrSplit(wrSplit),
    .wrData(wrData), .popReq(popReq), .rdMode(rdMode), .leftOut(leftOut),
    .rightOut(rightOut), .outValid(outValid), .level(level), .txThresh(txThresh),
    .canAccept(canAccept), .rxLevel(rxLevel), .rxThresh(rxThresh), .needDrain(needDrain),
    .clrSticky(clrSticky), .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wrValid = 1'b0; wrSplit = 1'b0; popReq = 1'b0; clrSticky = 1'b0;
  endtask

  task automatic doReset();
    idle();
    rstN = 1'b0;
    step();
    step();
    rstN = 1'b1;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    doReset();
    chk("R12 level", 32'(level), 32'd0);
    chk("R12 outValid", 32'(outValid), 32'd0);
    chk("R12 leftOut", leftOut, 32'd0);
    chk("R12 rightOut", rightOut, 32'd0);
    chk("R12 sticky", {30'd0, overflow, underflow}, 32'd0);
    chk("R6 canAccept at 0", 32'(canAccept), 32'd1);

    // Vector walk
    for (int i = 0; i < NVEC; i++) begin
      wrValid = VEC[i].wr; wrSplit = VEC[i].split; wrData = VEC[i].data;
      popReq = VEC[i].pop; rdMode = VEC[i].mode;
      step();
      idle();
      chk($sformatf("R11 valid vec%0d", i), 32'(outValid), 32'(VEC[i].expValid));
      chk($sformatf("R8 level vec%0d", i), 32'(level), 32'(VEC[i].expLevel));
      if (VEC[i].expValid) begin
        chk($sformatf("R4 left vec%0d", i), leftOut, VEC[i].expLeft);
        chk($sformatf("R4 right vec%0d", i), rightOut, VEC[i].expRight);
      end
    end
    chk("R9 underflow sticky", 32'(underflow), 32'd1);
    step();
    chk("R11 hold left", leftOut, 32'd0);
    clrSticky = 1'b1;
    step();
    idle();
    chk("R10 clear underflow", 32'(underflow), 32'd0);

    // Thresholds and fill
    doReset();
    wrSplit = 1'b0;
    for (int i = 0; i < 63; i++) begin
      wrValid = 1'b1; wrData = 32'hC000_0000 + 32'(i);
      step();
      if (i == 1) chk("R6 canAccept level 2 thr 3", 32'(canAccept), 32'd1);
      if (i == 2) chk("R6 canAccept level 3 thr 3", 32'(canAccept), 32'd0);
    end
    chk("R8 level 63", 32'(level), 32'd63);
    wrSplit = 1'b1; wrData = 32'hFFFF_EEEE;
    step();
    chk("R8 split at 63 dropped", 32'(level), 32'd63);
    chk("R8 overflow set", 32'(overflow), 32'd1);
    wrValid = 1'b0; wrSplit = 1'b0;
    step();
    chk("R8 overflow stays", 32'(overflow), 32'd1);
    clrSticky = 1'b1;
    step();
    clrSticky = 1'b0;
    chk("R10 clear overflow", 32'(overflow), 32'd0);
    wrValid = 1'b1; wrData = 32'hC000_003F;
    step();
    chk("R8 level 64", 32'(level), 32'd64);
    wrData = 32'h5555_5555;
    step();
    idle();
    chk("R8 full drop level", 32'(level), 32'd64);
    chk("R8 full drop overflow", 32'(overflow), 32'd1);
    popReq = 1'b1; rdMode = 3'd3;
    step();
    idle();
    chk("R1 oldest entry after fill", leftOut, 32'hC000_0000);
    chk("R8 level after pop", 32'(level), 32'd63);

    // Receive flag
    rxLevel = 7'd5; #1;
    chk("R7 needDrain equal", 32'(needDrain), 32'd0);
    rxLevel = 7'd6; #1;
    chk("R7 needDrain above", 32'(needDrain), 32'd1);

    // Force-enable clear
    doReset();
    forceEn = 1'b0;
    wrValid = 1'b1; wrSplit = 1'b1; wrData = 32'hDEADBEEF;
    step();
    chk("R5 split ignored", 32'(level), 32'd1);
    wrSplit = 1'b0; wrData = 32'h01020304;
    step();
    idle();
    popReq = 1'b1; rdMode = 3'd1;
    step();
    idle();
    chk("R5 left", leftOut, 32'hDEADBEEF);
    chk("R5 right", rightOut, 32'h01020304);
    chk("R5 level", 32'(level), 32'd0);

    // Reserved read format
    forceEn = 1'b1;
    wrValid = 1'b1; wrData = 32'hA1B2C3D4;
    step();
    wrData = 32'h0A0B0C0D;
    step();
    idle();
    popReq = 1'b1; rdMode = 3'd5;
    step();
    idle();
    chk("R3 mode5 left", leftOut, 32'hA1B2C3D4);
    chk("R3 mode5 right", rightOut, 32'h0A0B0C0D);
    chk("R3 mode5 level", 32'(level), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule